// File: doc/BRIEF.md
# Processor Control Register Unit

This block holds the three architectural control registers of a 32-bit processor core: the mode register (index 0), the page-fault address register (index 2) and the page-directory base register (index 3). Index 1 names a register that does not exist. Instruction execution reaches the registers through move-to and move-from requests that carry a 2-bit register index and 32-bit data. Read data comes back combinationally in the same cycle.

The unit also enforces the rules that tie the register bits together. It rejects paging without protection and strips reserved bits. It sets the task-switched flag on every task switch. It flags floating-point and WAIT instructions that must trap. It captures faulting linear addresses. It tells the translation cache when to flush.

Fault and flush outputs are combinational single-cycle pulses in the same cycle as the request that causes them. Register updates take effect at the following clock edge. Mode outputs for protected mode and paging follow the stored mode register.

Top module: `cpu_ctl_regs`

## Requirements
- R1: While `rst_n` is low, the mode register is cleared except bit 4 (coprocessor type), which takes the value of `cop_new_i`; the fault-address and directory-base registers clear to zero. After reset, `prot_mode_o` and `paging_o` are 0.
- R2: A move-to with index 0 (mode register) and a legal value stores the write data with bits 5..30 forced to zero. Bit positions are: protection enable bit 0, monitor-coprocessor bit 1, emulation bit 2, task-switched bit 3, coprocessor-type bit 4, paging enable bit 31. The stored value reads back with bits 5..30 at zero, and no fault is raised for them.
- R3: A move-to with index 0 whose data has bit 31 = 1 and bit 0 = 0 pulses `gp_fault_o` in that cycle and leaves the mode register unchanged.
- R4: Any move-to or move-from with index 1 pulses `ud_fault_o` in that cycle, changes no register and returns zero read data. The invalid-opcode fault takes priority over the general-protection fault.
- R5: A cycle with `task_sw_i` high sets the task-switched bit (bit 3) at the next edge, even if a mode-register write in the same cycle clears it.
- R6: `fp_instr_i` raises `nm_fault_o` in the same cycle when the emulation bit or the task-switched bit is 1.
- R7: `wait_instr_i` raises `nm_fault_o` only when both the monitor-coprocessor bit and the task-switched bit are 1. With the monitor bit at 0, WAIT never faults.
- R8: `pf_i` captures `pf_addr_i` into the fault-address register (index 2) at the next edge. A move-to with index 2 also loads it, and a page fault in the same cycle takes priority.
- R9: Writes to the directory-base register (index 3) keep bits 31..12 only; bits 11..0 always read as zero.
- R10: A move-to with index 3 pulses `tlb_flush_o` in that cycle, even when the value is unchanged.
- R11: A task switch loads `task_cr3_i` into the directory-base register, taking priority over a move-to with index 3 in the same cycle. It pulses `tlb_flush_o` only when bits 31..12 of the new value differ from the stored value.
- R12: `prot_mode_o` and `paging_o` show the stored protection and paging bits. Paging is never on while protection is off.
- R13: Fault outputs stay low in any cycle without a causing request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cop_new_i | input | 1 | Coprocessor type strap, sampled during reset |
| mov_to_i | input | 1 | Move-to-register request |
| mov_from_i | input | 1 | Move-from-register request |
| reg_idx_i | input | 2 | Register index (0 mode, 1 none, 2 fault address, 3 directory base) |
| wdata_i | input | 32 | Write data for move-to |
| rdata_o | output | 32 | Read data for move-from, zero otherwise |
| task_sw_i | input | 1 | Task-switch event strobe |
| task_cr3_i | input | 32 | Directory base loaded by the task switch |
| pf_i | input | 1 | Page-fault event strobe |
| pf_addr_i | input | 32 | Faulting linear address |
| fp_instr_i | input | 1 | Floating-point instruction qualifier |
| wait_instr_i | input | 1 | WAIT instruction qualifier |
| gp_fault_o | output | 1 | General-protection fault pulse |
| ud_fault_o | output | 1 | Invalid-opcode fault pulse |
| nm_fault_o | output | 1 | Device-not-available fault pulse |
| tlb_flush_o | output | 1 | Translation-cache flush pulse |
| prot_mode_o | output | 1 | Protected mode active |
| paging_o | output | 1 | Paging enabled |

## Verification
A wrong mode-register state shows up one cycle after the faulty update. It appears on `prot_mode_o` and `paging_o`, and also on `nm_fault_o` for the next floating-point or WAIT qualifier. A stale or mis-masked directory base shows up as a missing or spurious `tlb_flush_o` on the next task switch, and as wrong read data on the next move-from. Every step of the bench compares all outputs in the cycle of the request, so a corrupted bit is caught within one or two requests.

// File: rtl/ctlreg_pkg.sv
package ctlreg_pkg;

  localparam int XLEN     = 32;
  localparam int IDX_W    = 2;
  localparam int NUM_IDX  = 1 << IDX_W;
  localparam int PAGE_OFS = 12;

  localparam int B_PE = 0;
  localparam int B_MP = 1;
  localparam int B_EM = 2;
  localparam int B_TS = 3;
  localparam int B_ET = 4;
  localparam int B_PG = XLEN - 1;

  typedef enum logic [IDX_W-1:0] {
    SEL_MODE   = 2'd0,
    SEL_NONE   = 2'd1,
    SEL_PFADDR = 2'd2,
    SEL_DIRBAS = 2'd3
  } cr_sel_e;

  // keep only defined mode-register bits
  function automatic logic [XLEN-1:0] mode_clean(input logic [XLEN-1:0] v);
    logic [XLEN-1:0] r;
    r = '0;
    r[B_PE] = v[B_PE];
    r[B_MP] = v[B_MP];
    r[B_EM] = v[B_EM];
    r[B_TS] = v[B_TS];
    r[B_ET] = v[B_ET];
    r[B_PG] = v[B_PG];
    return r;
  endfunction

  // paging requires protection
  function automatic logic mode_legal(input logic [XLEN-1:0] v);
    return !(v[B_PG] && !v[B_PE]);
  endfunction

  function automatic logic fp_blocked(input logic em, input logic ts);
    return em | ts;
  endfunction

  function automatic logic wait_blocked(input logic mp, input logic ts);
    return mp & ts;
  endfunction

endpackage

// File: rtl/ctl_fault_decode.sv
module ctl_fault_decode
  import ctlreg_pkg::*;
(
  input  logic            mov_to_i,
  input  logic            mov_from_i,
  input  logic [IDX_W-1:0] idx_i,
  input  logic [XLEN-1:0] wdata_i,
  input  logic            fp_instr_i,
  input  logic            wait_instr_i,
  input  logic [XLEN-1:0] mode_q_i,
  output logic            ud_o,
  output logic            gp_o,
  output logic            nm_o,
  output logic            mode_we_o,
  output logic            pfaddr_we_o,
  output logic            dirbas_we_o
);

  logic [NUM_IDX-1:0] sel_hit;

  for (genvar i = 0; i < NUM_IDX; i++) begin : g_sel
    assign sel_hit[i] = mov_to_i && (idx_i == IDX_W'(i));
  end

  logic access_none;
  logic bad_mode;

  assign access_none = (mov_to_i || mov_from_i) && (idx_i == SEL_NONE);
  assign bad_mode    = sel_hit[SEL_MODE] && !mode_legal(wdata_i);

  assign ud_o = access_none;
  assign gp_o = bad_mode && !access_none;

  assign nm_o = (fp_instr_i   && fp_blocked(mode_q_i[B_EM], mode_q_i[B_TS])) ||
                (wait_instr_i && wait_blocked(mode_q_i[B_MP], mode_q_i[B_TS]));

  assign mode_we_o   = sel_hit[SEL_MODE] && !bad_mode;
  assign pfaddr_we_o = sel_hit[SEL_PFADDR];
  assign dirbas_we_o = sel_hit[SEL_DIRBAS];

endmodule

// File: rtl/ctl_mode_reg.sv
module ctl_mode_reg
  import ctlreg_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic            et_strap_i,
  input  logic            we_i,
  input  logic [XLEN-1:0] wdata_i,
  input  logic            ts_set_i,
  output logic [XLEN-1:0] mode_q_o
);

  logic [XLEN-1:0] mode_q;
  logic [XLEN-1:0] mode_d;

  always_comb begin
    mode_d = mode_q;
    if (we_i) mode_d = mode_clean(wdata_i);
    if (ts_set_i) mode_d[B_TS] = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q       <= '0;
      mode_q[B_ET] <= et_strap_i;
    end else begin
      mode_q <= mode_d;
    end
  end

  assign mode_q_o = mode_q;

endmodule

// File: rtl/ctl_page_regs.sv
module ctl_page_regs
  import ctlreg_pkg::*;
#(
  parameter int OFS = PAGE_OFS
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            pf_i,
  input  logic [XLEN-1:0] pf_addr_i,
  input  logic            pfaddr_we_i,
  input  logic            dirbas_we_i,
  input  logic [XLEN-1:0] wdata_i,
  input  logic            ts_load_i,
  input  logic [XLEN-1:0] ts_dir_i,
  output logic [XLEN-1:0] pfaddr_q_o,
  output logic [XLEN-1:0] dirbas_q_o,
  output logic            flush_o
);

  localparam int BASE_W = XLEN - OFS;

  logic [XLEN-1:0]   pfaddr_q;
  logic [BASE_W-1:0] base_q;
  logic [BASE_W-1:0] base_d;
  logic              base_differs;

  assign base_differs = ts_dir_i[XLEN-1:OFS] != base_q;

  always_comb begin
    base_d = base_q;
    if (ts_load_i)        base_d = ts_dir_i[XLEN-1:OFS];
    else if (dirbas_we_i) base_d = wdata_i[XLEN-1:OFS];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pfaddr_q <= '0;
      base_q   <= '0;
    end else begin
      if (pf_i)             pfaddr_q <= pf_addr_i;
      else if (pfaddr_we_i) pfaddr_q <= wdata_i;
      base_q <= base_d;
    end
  end

  assign flush_o    = ts_load_i ? base_differs : dirbas_we_i;
  assign pfaddr_q_o = pfaddr_q;
  assign dirbas_q_o = {base_q, {OFS{1'b0}}};

endmodule

// File: rtl/cpu_ctl_regs.sv
module cpu_ctl_regs
  import ctlreg_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cop_new_i,
  input  logic             mov_to_i,
  input  logic             mov_from_i,
  input  logic [1:0]       reg_idx_i,
  input  logic [31:0]      wdata_i,
  output logic [31:0]      rdata_o,
  input  logic             task_sw_i,
  input  logic [31:0]      task_cr3_i,
  input  logic             pf_i,
  input  logic [31:0]      pf_addr_i,
  input  logic             fp_instr_i,
  input  logic             wait_instr_i,
  output logic             gp_fault_o,
  output logic             ud_fault_o,
  output logic             nm_fault_o,
  output logic             tlb_flush_o,
  output logic             prot_mode_o,
  output logic             paging_o
);

  logic [XLEN-1:0] cr0_q;
  logic [XLEN-1:0] cr2_q;
  logic [XLEN-1:0] cr3_q;
  logic            mode_we;
  logic            pfaddr_we;
  logic            dirbas_we;

  ctl_fault_decode u_dec (
    .mov_to_i     (mov_to_i),
    .mov_from_i   (mov_from_i),
    .idx_i        (reg_idx_i),
    .wdata_i      (wdata_i),
    .fp_instr_i   (fp_instr_i),
    .wait_instr_i (wait_instr_i),
    .mode_q_i     (cr0_q),
    .ud_o         (ud_fault_o),
    .gp_o         (gp_fault_o),
    .nm_o         (nm_fault_o),
    .mode_we_o    (mode_we),
    .pfaddr_we_o  (pfaddr_we),
    .dirbas_we_o  (dirbas_we)
  );

  ctl_mode_reg u_mode (
    .clk        (clk),
    .rst_n      (rst_n),
    .et_strap_i (cop_new_i),
    .we_i       (mode_we),
    .wdata_i    (wdata_i),
    .ts_set_i   (task_sw_i),
    .mode_q_o   (cr0_q)
  );

  ctl_page_regs #(.OFS(PAGE_OFS)) u_page (
    .clk         (clk),
    .rst_n       (rst_n),
    .pf_i        (pf_i),
    .pf_addr_i   (pf_addr_i),
    .pfaddr_we_i (pfaddr_we),
    .dirbas_we_i (dirbas_we),
    .wdata_i     (wdata_i),
    .ts_load_i   (task_sw_i),
    .ts_dir_i    (task_cr3_i),
    .pfaddr_q_o  (cr2_q),
    .dirbas_q_o  (cr3_q),
    .flush_o     (tlb_flush_o)
  );

  always_comb begin
    rdata_o = '0;
    if (mov_from_i) begin
      unique case (cr_sel_e'(reg_idx_i))
        SEL_MODE:   rdata_o = cr0_q;
        SEL_PFADDR: rdata_o = cr2_q;
        SEL_DIRBAS: rdata_o = cr3_q;
        default:    rdata_o = '0;
      endcase
    end
  end

  assign prot_mode_o = cr0_q[B_PE];
  assign paging_o    = cr0_q[B_PG];

endmodule

// File: rtl/cpu_ctl_regs_chk.sv
module cpu_ctl_regs_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        mov_to_i,
  input logic        mov_from_i,
  input logic [1:0]  reg_idx_i,
  input logic [31:0] wdata_i,
  input logic        task_sw_i,
  input logic [31:0] task_cr3_i,
  input logic        pf_i,
  input logic [31:0] pf_addr_i,
  input logic        fp_instr_i,
  input logic        wait_instr_i,
  input logic        gp_fault_o,
  input logic        ud_fault_o,
  input logic        nm_fault_o,
  input logic        tlb_flush_o,
  input logic        prot_mode_o,
  input logic        paging_o,
  input logic [31:0] cr0_q,
  input logic [31:0] cr2_q,
  input logic [31:0] cr3_q
);

  assert_gp_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (gp_fault_o && !task_sw_i) |=> $stable(cr0_q));

  assert_gp_cause_R3: assert property (@(posedge clk) disable iff (!rst_n)
    gp_fault_o |-> (mov_to_i && reg_idx_i == 2'd0 && wdata_i[31] && !wdata_i[0]));

  assert_ud_cr1_R4: assert property (@(posedge clk) disable iff (!rst_n)
    ((mov_to_i || mov_from_i) && reg_idx_i == 2'd1) |-> (ud_fault_o && !gp_fault_o));

  assert_ts_set_R5: assert property (@(posedge clk) disable iff (!rst_n)
    task_sw_i |=> cr0_q[3]);

  assert_fp_trap_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (fp_instr_i && (cr0_q[2] || cr0_q[3])) |-> nm_fault_o);

  assert_wait_quiet_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (wait_instr_i && !fp_instr_i && !cr0_q[1]) |-> !nm_fault_o);

  assert_pf_capture_R8: assert property (@(posedge clk) disable iff (!rst_n)
    pf_i |=> (cr2_q == $past(pf_addr_i)));

  assert_dir_align_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (mov_to_i && reg_idx_i == 2'd3 && !task_sw_i) |=>
      (cr3_q == ($past(wdata_i) & 32'hFFFF_F000)));

  assert_flush_write_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (mov_to_i && reg_idx_i == 2'd3 && !task_sw_i) |-> tlb_flush_o);

  assert_same_noflush_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (task_sw_i && task_cr3_i[31:12] == cr3_q[31:12]) |-> !tlb_flush_o);

  assert_paging_needs_pe_R12: assert property (@(posedge clk) disable iff (!rst_n)
    paging_o |-> prot_mode_o);

  assert_quiet_R13: assert property (@(posedge clk) disable iff (!rst_n)
    !(mov_to_i || mov_from_i) |-> (!ud_fault_o && !gp_fault_o));

endmodule

bind cpu_ctl_regs cpu_ctl_regs_chk u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .mov_to_i     (mov_to_i),
  .mov_from_i   (mov_from_i),
  .reg_idx_i    (reg_idx_i),
  .wdata_i      (wdata_i),
  .task_sw_i    (task_sw_i),
  .task_cr3_i   (task_cr3_i),
  .pf_i         (pf_i),
  .pf_addr_i    (pf_addr_i),
  .fp_instr_i   (fp_instr_i),
  .wait_instr_i (wait_instr_i),
  .gp_fault_o   (gp_fault_o),
  .ud_fault_o   (ud_fault_o),
  .nm_fault_o   (nm_fault_o),
  .tlb_flush_o  (tlb_flush_o),
  .prot_mode_o  (prot_mode_o),
  .paging_o     (paging_o),
  .cr0_q        (cr0_q),
  .cr2_q        (cr2_q),
  .cr3_q        (cr3_q)
);

// File: tb/cpu_ctl_regs_tb_top.sv
module cpu_ctl_regs_tb_top;

  localparam int CLK_PER = 10;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        cop_new_i;
  logic        mov_to_i, mov_from_i;
  logic [1:0]  reg_idx_i;
  logic [31:0] wdata_i, rdata_o;
  logic        task_sw_i;
  logic [31:0] task_cr3_i;
  logic        pf_i;
  logic [31:0] pf_addr_i;
  logic        fp_instr_i, wait_instr_i;
  logic        gp_fault_o, ud_fault_o, nm_fault_o, tlb_flush_o;
  logic        prot_mode_o, paging_o;

  always #(CLK_PER/2) clk = ~clk;

  cpu_ctl_regs dut_i (.*);

  typedef struct {
    logic        gp, ud, nm, fl, pm, pg;
    logic [31:0] rd;
    string       req;
  } exp_t;

  exp_t q[$];
  int   checks = 0;
  int   errors = 0;
  event smp_ev;

  logic [31:0] m_cr0, m_cr2, m_cr3;

  task automatic cmp(input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  initial begin
    forever begin
      exp_t e;
      @(smp_ev);
      #1;
      e = q.pop_front();
      cmp(e.req, "gp_fault", 32'(gp_fault_o), 32'(e.gp));
      cmp(e.req, "ud_fault", 32'(ud_fault_o), 32'(e.ud));
      cmp(e.req, "nm_fault", 32'(nm_fault_o), 32'(e.nm));
      cmp(e.req, "flush", 32'(tlb_flush_o), 32'(e.fl));
      cmp(e.req, "prot_mode", 32'(prot_mode_o), 32'(e.pm));
      cmp(e.req, "paging", 32'(paging_o), 32'(e.pg));
      cmp(e.req, "rdata", rdata_o, e.rd);
    end
  end

  task automatic step(input logic mt, input logic mf, input logic [1:0] idx,
                      input logic [31:0] wd, input logic tsw, input logic [31:0] tcr3,
                      input logic pf, input logic [31:0] pfa,
                      input logic fp, input logic wt, input string req);
    exp_t e;
    logic [31:0] nxt0;
    @(negedge clk);
    mov_to_i = mt; mov_from_i = mf; reg_idx_i = idx; wdata_i = wd;
    task_sw_i = tsw; task_cr3_i = tcr3; pf_i = pf; pf_addr_i = pfa;
    fp_instr_i = fp; wait_instr_i = wt;
    e.req = req;
    e.ud  = (mt || mf) && idx == 2'd1;
    e.gp  = mt && idx == 2'd0 && wd[31] == 1'b1 && wd[0] == 1'b0;
    e.nm  = (fp && (m_cr0[2] || m_cr0[3])) || (wt && m_cr0[1] && m_cr0[3]);
    if (tsw) e.fl = ({tcr3[31:12], 12'h000} != m_cr3);
    else     e.fl = mt && idx == 2'd3;
    e.pm = m_cr0[0];
    e.pg = m_cr0[31];
    e.rd = 32'h0;
    if (mf) begin
      if (idx == 2'd0) e.rd = m_cr0;
      if (idx == 2'd2) e.rd = m_cr2;
      if (idx == 2'd3) e.rd = m_cr3;
    end
    q.push_back(e);
    -> smp_ev;
    nxt0 = m_cr0;
    if (mt && idx == 2'd0 && !e.gp) nxt0 = {wd[31], 26'h0, wd[4:0]};
    if (tsw) nxt0[3] = 1'b1;
    m_cr0 = nxt0;
    if (pf) m_cr2 = pfa;
    else if (mt && idx == 2'd2) m_cr2 = wd;
    if (tsw) m_cr3 = tcr3 & 32'hFFFF_F000;
    else if (mt && idx == 2'd3) m_cr3 = wd & 32'hFFFF_F000;
  endtask

  task automatic wr(input logic [1:0] idx, input logic [31:0] wd, input string req);
    step(1, 0, idx, wd, 0, 0, 0, 0, 0, 0, req);
  endtask

  task automatic rd(input logic [1:0] idx, input string req);
    step(0, 1, idx, 0, 0, 0, 0, 0, 0, 0, req);
  endtask

  task automatic tswitch(input logic [31:0] tcr3, input string req);
    step(0, 0, 0, 0, 1, tcr3, 0, 0, 0, 0, req);
  endtask

  task automatic instr(input logic fp, input logic wt, input string req);
    step(0, 0, 0, 0, 0, 0, 0, 0, fp, wt, req);
  endtask

  task automatic do_reset(input logic strap);
    @(negedge clk);
    rst_n = 1'b0; cop_new_i = strap;
    mov_to_i = 0; mov_from_i = 0; reg_idx_i = 0; wdata_i = 0;
    task_sw_i = 0; task_cr3_i = 0; pf_i = 0; pf_addr_i = 0;
    fp_instr_i = 0; wait_instr_i = 0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    m_cr0 = {27'h0, strap, 4'h0};
    m_cr2 = 32'h0;
    m_cr3 = 32'h0;
  endtask

  task automatic summary;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
  endtask

  initial begin
    #(CLK_PER * 50000);
    errors++;
    $display("FAIL watchdog expired");
    summary();
    $finish;
  end

  initial begin
    do_reset(1'b1);
    rd(2'd0, "R1 reset mode reg");
    rd(2'd2, "R1 reset fault addr");
    rd(2'd3, "R1 reset dir base");

    wr(2'd0, 32'hFFFF_FFFF, "R2 write all ones");
    rd(2'd0, "R2 reserved bits read zero");
    instr(0, 0, "R12 mode outputs on");
    wr(2'd0, 32'h8000_0000, "R3 paging without protection");
    rd(2'd0, "R3 mode reg unchanged");
    wr(2'd0, 32'h0000_0001, "R2 protection only");
    rd(2'd0, "R2 readback PE");

    wr(2'd1, 32'h8000_0000, "R4 write index 1");
    rd(2'd1, "R4 read index 1");
    rd(2'd0, "R4 mode reg untouched");

    wr(2'd0, 32'h0000_0000, "R2 clear all");
    instr(1, 0, "R6 fp clear");
    instr(0, 1, "R7 wait clear");
    tswitch(32'h0000_0000, "R5 task switch");
    rd(2'd0, "R5 TS set");
    instr(1, 0, "R6 fp with TS");
    instr(0, 1, "R7 wait with TS no MP");
    wr(2'd0, 32'h0000_000A, "R7 set MP and TS");
    instr(0, 1, "R7 wait MP TS");
    wr(2'd0, 32'h0000_0004, "R6 set EM only");
    instr(1, 0, "R6 fp with EM");
    instr(0, 1, "R7 wait EM only");
    step(1, 0, 2'd0, 32'h0, 1, 32'h0, 0, 0, 0, 0, "R5 TS wins over write");
    rd(2'd0, "R5 TS after combined");

    step(0, 0, 0, 0, 0, 0, 1, 32'hDEAD_BEEF, 0, 0, "R8 page fault");
    rd(2'd2, "R8 fault addr readback");
    wr(2'd2, 32'h1357_9BDF, "R8 move to fault addr");
    rd(2'd2, "R8 move readback");
    step(1, 0, 2'd2, 32'h1111_1111, 0, 0, 1, 32'h2222_2222, 0, 0, "R8 fault wins");
    rd(2'd2, "R8 fault wins readback");

    wr(2'd3, 32'h1234_5ABC, "R10 dir base write");
    rd(2'd3, "R9 low bits zero");
    wr(2'd3, 32'h1234_5000, "R10 same value flush");
    tswitch(32'h1234_5FFF, "R11 same base no flush");
    rd(2'd3, "R9 after task load");
    tswitch(32'hABCD_E123, "R11 new base flush");
    rd(2'd3, "R11 new base readback");
    step(1, 0, 2'd3, 32'h5555_5000, 1, 32'hABCD_E000, 0, 0, 0, 0, "R11 task load wins");
    rd(2'd3, "R11 task load readback");
    instr(0, 0, "R13 idle no fault");

    do_reset(1'b0);
    rd(2'd0, "R1 reset strap zero");
    instr(0, 0, "R12 mode outputs off");

    repeat (3) @(negedge clk);
    summary();
    $finish;
  end

endmodule